// File: doc/BRIEF.md
# Accumulator Shift Unit

This block holds two 40-bit DSP accumulators and shifts either of them in place by a signed amount taken from a general data register. Each accepted command picks one accumulator, chooses an arithmetic or a logical shift, and supplies a 32-bit source word. The low six bits of that word, read as a signed number, give the shift. A negative or zero amount shifts right. A positive amount shifts left. The result goes back into the same accumulator in the same cycle, and that accumulator's overflow flag is cleared.

Each accumulator is presented as an 8-bit extension part and a 32-bit word part. A separate load port writes a full 40-bit value and an overflow flag into one accumulator. This port stands in for the multiply-accumulate datapath, which is not part of this block.

Commands arrive on a valid/ready handshake. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low in any cycle where the load port is active, because a load has priority. The producer must then hold the command stable until it is accepted. Otherwise the block takes one command per cycle.

Top module: `acc_shifter`

## Requirements
- R1: After reset, both accumulators read zero in their extension and word parts, and both overflow flags are 0.
- R2: The shift amount is source bits 5:0 read as a two's-complement number, giving a range of -32 to +31. Source bits 31:6 have no effect on the result.
- R3: For an arithmetic command (`cmd_logical`=0) with an amount of zero or less, the selected 40-bit value is shifted right by the magnitude of the amount. The vacated bits are filled with copies of bit 39.
- R4: For a logical command (`cmd_logical`=1) with an amount of zero or less, the selected 40-bit value is shifted right by the magnitude of the amount. The vacated bits are filled with zeros.
- R5: For a positive amount, both command types shift left by that amount and fill with zeros. Bits moved past bit 39 are lost, and the result does not saturate.
- R6: The result's bits 39:32 appear on the extension output of the selected accumulator, and bits 31:0 on its word output. Both appear in the cycle after acceptance.
- R7: An accepted command clears the overflow flag of the selected accumulator at the same edge as the result write. The other accumulator's value and flag are unchanged.
- R8: `cmd_sel`=0 picks accumulator 0 and `cmd_sel`=1 picks accumulator 1.
- R9: `cmd_ready` is low whenever `ld_en` is high. Without an accepted command or a load, no accumulator value or flag changes.
- R10: A load with `ld_en`=1 writes `ld_val` to the accumulator chosen by `ld_sel`, and sets its flag to `ld_av`, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | Accumulator to load |
| ld_val | input | 40 | Value to load |
| ld_av | input | 1 | Overflow flag value to load |
| cmd_valid | input | 1 | Shift command valid |
| cmd_ready | output | 1 | Shift command accepted when high |
| cmd_sel | input | 1 | Accumulator to shift |
| cmd_logical | input | 1 | 1 = logical shift, 0 = arithmetic shift |
| cmd_src | input | 32 | Source register; bits 5:0 carry the amount |
| acc_ext_o | output | 2x8 | Extension parts, index = accumulator |
| acc_word_o | output | 2x32 | Word parts, index = accumulator |
| av_o | output | 2 | Overflow flags, index = accumulator |

## Verification
The shift is tried on several kinds of values:
- Values with bit 39 set and clear, shifted right by both command types. These separate sign fill from zero fill, and show whether the fill starts at bit 39 rather than bit 31.
- Amounts at the edges of the range: 0, -1, -32 and +31. These expose errors in decoding the sign and in computing the magnitude.
- Left shifts that push set bits past bit 39. These show that high bits are dropped rather than saturated.
- Sources with junk in bits 31:6. These show that only the six-bit field is used.

The other accumulator's value and flag are checked after every step, so a wrong select or a flag cleared on the wrong accumulator shows up. Load/command collisions show whether the shift was held off.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  typedef enum logic {
    SHOP_ARITH = 1'b0,
    SHOP_LOGIC = 1'b1
  } shop_e;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shdir_e;

endpackage

// File: rtl/acc_amt_decode.sv
module acc_amt_decode #(
  parameter int SRC_W = 32,
  parameter int AMT_W = 6
) (
  input  logic [SRC_W-1:0]               src,
  output acc_shift_pkg::shdir_e          dir,
  output logic [AMT_W-1:0]               mag
);
  import acc_shift_pkg::*;

  logic signed [AMT_W-1:0] amt;

  always_comb begin
    amt = $signed(src[AMT_W-1:0]);
    if (amt <= 0) begin
      dir = DIR_RIGHT;
      mag = AMT_W'(-amt);
    end else begin
      dir = DIR_LEFT;
      mag = AMT_W'(amt);
    end
  end

endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core #(
  parameter int ACC_W = 40,
  parameter int MAG_W = 6
) (
  input  logic [ACC_W-1:0]        a,
  input  acc_shift_pkg::shop_e    op,
  input  acc_shift_pkg::shdir_e   dir,
  input  logic [MAG_W-1:0]        mag,
  output logic [ACC_W-1:0]        y
);
  import acc_shift_pkg::*;

  localparam int WIDE_W = 2 * ACC_W;

  logic              fill;
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] wide_sh;

  always_comb begin
    fill    = (op == SHOP_ARITH) ? a[ACC_W-1] : 1'b0;
    wide    = {{ACC_W{fill}}, a};
    wide_sh = wide >> mag;
    if (dir == DIR_RIGHT) y = wide_sh[ACC_W-1:0];
    else                  y = a << mag;
  end

endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int ACC_W   = 40,
  parameter int NUM_ACC = 2,
  parameter int SEL_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [SEL_W-1:0]              ld_sel,
  input  logic [ACC_W-1:0]              ld_val,
  input  logic                          ld_av,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [ACC_W-1:0]              wr_val,
  output logic [NUM_ACC-1:0][ACC_W-1:0] acc_q,
  output logic [NUM_ACC-1:0]            av_q
);

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
        av_q[i]  <= 1'b0;
      end else if (ld_en && ld_sel == SEL_W'(i)) begin
        acc_q[i] <= ld_val;
        av_q[i]  <= ld_av;
      end else if (wr_en && wr_sel == SEL_W'(i)) begin
        acc_q[i] <= wr_val;
        av_q[i]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int EXT_W   = 8,
  parameter int WORD_W  = 32,
  parameter int SRC_W   = 32,
  parameter int AMT_W   = 6,
  parameter int NUM_ACC = 2,
  localparam int ACC_W  = EXT_W + WORD_W,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_en,
  input  logic [SEL_W-1:0]                ld_sel,
  input  logic [ACC_W-1:0]                ld_val,
  input  logic                            ld_av,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic [SEL_W-1:0]                cmd_sel,
  input  logic                            cmd_logical,
  input  logic [SRC_W-1:0]                cmd_src,
  output logic [NUM_ACC-1:0][EXT_W-1:0]   acc_ext_o,
  output logic [NUM_ACC-1:0][WORD_W-1:0]  acc_word_o,
  output logic [NUM_ACC-1:0]              av_o
);
  import acc_shift_pkg::*;

  logic                          fire;
  shdir_e                        dir;
  shop_e                         op;
  logic [AMT_W-1:0]              mag;
  logic [ACC_W-1:0]              cur;
  logic [ACC_W-1:0]              res;
  logic [NUM_ACC-1:0][ACC_W-1:0] acc_q;

  assign cmd_ready = ~ld_en;
  assign fire      = cmd_valid & cmd_ready;
  assign op        = cmd_logical ? SHOP_LOGIC : SHOP_ARITH;
  assign cur       = acc_q[cmd_sel];

  acc_amt_decode #(.SRC_W(SRC_W), .AMT_W(AMT_W)) u_dec (
    .src (cmd_src),
    .dir (dir),
    .mag (mag)
  );

  acc_shift_core #(.ACC_W(ACC_W), .MAG_W(AMT_W)) u_core (
    .a   (cur),
    .op  (op),
    .dir (dir),
    .mag (mag),
    .y   (res)
  );

  acc_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .ld_av  (ld_av),
    .wr_en  (fire),
    .wr_sel (cmd_sel),
    .wr_val (res),
    .acc_q  (acc_q),
    .av_q   (av_o)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_split
    assign acc_ext_o[i]  = acc_q[i][ACC_W-1:WORD_W];
    assign acc_word_o[i] = acc_q[i][WORD_W-1:0];
  end

endmodule

// File: rtl/acc_shifter_chk.sv
module acc_shifter_chk #(
  parameter int EXT_W   = 8,
  parameter int WORD_W  = 32,
  parameter int SRC_W   = 32,
  parameter int AMT_W   = 6,
  parameter int NUM_ACC = 2,
  parameter int SEL_W   = 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            ld_en,
  input logic [SEL_W-1:0]                ld_sel,
  input logic                            cmd_valid,
  input logic                            cmd_ready,
  input logic [SEL_W-1:0]                cmd_sel,
  input logic [SRC_W-1:0]                cmd_src,
  input logic [NUM_ACC-1:0][EXT_W-1:0]   acc_ext_o,
  input logic [NUM_ACC-1:0][WORD_W-1:0]  acc_word_o,
  input logic [NUM_ACC-1:0]              av_o
);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !cmd_ready);

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !fire) |=> ($stable(acc_ext_o) && $stable(acc_word_o) && $stable(av_o)));

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_chk
    assert_av_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_sel == SEL_W'(i)) |=> !av_o[i]);

    assert_other_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_sel != SEL_W'(i) && !(ld_en && ld_sel == SEL_W'(i)))
      |=> ($stable(acc_ext_o[i]) && $stable(acc_word_o[i]) && $stable(av_o[i])));

    assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_sel == SEL_W'(i) && cmd_src[AMT_W-1:0] == '0)
      |=> ($stable(acc_ext_o[i]) && $stable(acc_word_o[i])));
  end

endmodule

bind acc_shifter acc_shifter_chk #(
  .EXT_W(EXT_W), .WORD_W(WORD_W), .SRC_W(SRC_W), .AMT_W(AMT_W),
  .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_en      (ld_en),
  .ld_sel     (ld_sel),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_sel    (cmd_sel),
  .cmd_src    (cmd_src),
  .acc_ext_o  (acc_ext_o),
  .acc_word_o (acc_word_o),
  .av_o       (av_o)
);

// File: tb/tb_acc_shifter.sv
module tb_acc_shifter;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 ld_en = 1'b0;
  logic [0:0]           ld_sel = '0;
  logic [39:0]          ld_val = '0;
  logic                 ld_av = 1'b0;
  logic                 cmd_valid = 1'b0;
  logic                 cmd_ready;
  logic [0:0]           cmd_sel = '0;
  logic                 cmd_logical = 1'b0;
  logic [31:0]          cmd_src = '0;
  logic [1:0][7:0]      acc_ext_o;
  logic [1:0][31:0]     acc_word_o;
  logic [1:0]           av_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [39:0] m_acc [2];
  logic        m_av  [2];

  always #2 clk = ~clk;

  acc_shifter dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .ld_av(ld_av), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sel(cmd_sel),
    .cmd_logical(cmd_logical), .cmd_src(cmd_src), .acc_ext_o(acc_ext_o),
    .acc_word_o(acc_word_o), .av_o(av_o)
  );

  function automatic logic [39:0] ref_shift(logic [39:0] v, logic lg, logic [31:0] src);
    int amt;
    logic signed [39:0] sv;
    amt = src[5] ? int'(src[5:0]) - 64 : int'(src[5:0]);
    sv  = $signed(v);
    if (amt > 0)  return v << amt;
    if (lg)       return v >> (-amt);
    return 40'(sv >>> (-amt));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int i = 0; i < 2; i++) begin
      chk(req, {24'h0, acc_ext_o[i], acc_word_o[i]}, {24'h0, m_acc[i]});
      chk(req, {63'h0, av_o[i]}, {63'h0, m_av[i]});
    end
  endtask

  task automatic do_load(logic s, logic [39:0] v, logic f);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_val = v; ld_av = f;
    @(negedge clk);
    ld_en = 1'b0;
    m_acc[s] = v; m_av[s] = f;
  endtask

  task automatic do_shift(string req, logic s, logic lg, logic [31:0] src);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = s; cmd_logical = lg; cmd_src = src;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_acc[s] = ref_shift(m_acc[s], lg, src);
    m_av[s]  = 1'b0;
    chk_all(req);
  endtask

  task automatic t_reset();
    m_acc[0] = '0; m_acc[1] = '0; m_av[0] = 0; m_av[1] = 0;
    chk_all("R1");
  endtask

  task automatic t_arith_right();
    do_load(0, 40'h80_1234_5678, 1);
    do_shift("R3", 0, 0, 32'h0000_003F);
    do_shift("R3", 0, 0, 32'h0000_0038);
    do_load(0, 40'h7F_F000_0001, 1);
    do_shift("R3", 0, 0, 32'h0000_0020);
    do_load(0, 40'hC3_0000_0000, 0);
    do_shift("R3", 0, 0, 32'h0000_0020);
    do_shift("R3", 0, 0, 32'h0000_0000);
  endtask

  task automatic t_logic_right();
    do_load(1, 40'h80_1234_5678, 1);
    do_shift("R4", 1, 1, 32'h0000_003F);
    do_load(1, 40'hFF_FFFF_FFFF, 1);
    do_shift("R4", 1, 1, 32'h0000_0020);
    do_shift("R4", 1, 1, 32'h0000_0039);
  endtask

  task automatic t_left();
    do_load(0, 40'h01_8000_0001, 1);
    do_shift("R5", 0, 0, 32'h0000_0008);
    do_load(0, 40'h40_0000_0001, 0);
    do_shift("R5", 0, 1, 32'h0000_0001);
    do_load(1, 40'h00_0000_0003, 1);
    do_shift("R5", 1, 0, 32'h0000_001F);
    chk("R6", {56'h0, acc_ext_o[1]}, {56'h0, m_acc[1][39:32]});
    chk("R6", {32'h0, acc_word_o[1]}, {32'h0, m_acc[1][31:0]});
  endtask

  task automatic t_amount_field();
    do_load(0, 40'h00_0000_00F0, 1);
    do_shift("R2", 0, 0, 32'hFFFF_FFC2);
    do_shift("R2", 0, 1, 32'h1234_5640);
    do_shift("R2", 0, 0, 32'hAAAA_AAFE);
  endtask

  task automatic t_select();
    do_load(0, 40'h11_2222_3333, 1);
    do_load(1, 40'h44_5555_6666, 1);
    do_shift("R8", 1, 0, 32'h0000_0004);
    chk("R7", {63'h0, av_o[0]}, 64'h1);
    do_shift("R8", 0, 1, 32'h0000_003C);
    chk_all("R10");
  endtask

  task automatic t_backpressure();
    do_load(0, 40'h12_3456_789A, 0);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 0; ld_val = 40'hF0_0000_000F; ld_av = 1'b1;
    cmd_valid = 1'b1; cmd_sel = 0; cmd_logical = 1'b0; cmd_src = 32'h0000_0004;
    #0.1;
    chk("R9", {63'h0, cmd_ready}, 64'h0);
    @(negedge clk);
    ld_en = 1'b0;
    m_acc[0] = 40'hF0_0000_000F; m_av[0] = 1'b1;
    chk_all("R9");
    @(negedge clk);
    cmd_valid = 1'b0;
    m_acc[0] = ref_shift(m_acc[0], 0, 32'h4); m_av[0] = 1'b0;
    chk_all("R9");
    repeat (3) @(negedge clk);
    chk_all("R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith_right();
    t_logic_right();
    t_left();
    t_amount_field();
    t_select();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

endmodule